// File: doc/BRIEF.md
# Storage-Fed Shift Register with Shared Parallel Lines

This block pairs a parallel holding register with a serial shift register of the same width. The holding register samples a set of shared parallel lines when its capture strobe rises. The shift register can copy the holding register in parallel, shift one place toward its top stage on a rising edge of the shift strobe, or be cleared. The top stage always appears on a serial output.

The shared parallel lines are split into a read value, a drive value and a drive enable, so a pad ring or a bench can model the tri-state pins. With the output enable inactive, the lines are only read. With it active, they carry the shift-register stages. The output enable never changes how the registers behave. Everything runs on one system clock. Both strobes are sampled every cycle and their rising edges are found inside the block. The parallel load and the functional clear are level conditions that are checked on every cycle.

Top module: `ssr_top`

## Requirements
- R1: A rising edge of `cap_stb` (high this cycle, low the cycle before) copies `pin_i` into the holding register. With no such edge, the holding register keeps its value.
- R2: While `ld_n` is low, `sh_stb` is low and `clr_n` is high, the shift register takes the holding register's value on every clock cycle.
- R3: While `sh_stb` is high, a low `ld_n` loads nothing, and the shift register keeps its value.
- R4: With `ld_n` high, `clr_n` high and `sh_en_n` low, each rising edge of `sh_stb` moves every stage n to stage n+1 (bit n to bit n+1 of `pin_o`) and puts the serial bit into stage 0 (bit 0). A strobe held high shifts only once.
- R5: The serial bit is `ser_a` when `ser_sel` is 0 and `ser_b` when `ser_sel` is 1.
- R6: While `sh_en_n` is high, rising edges of `sh_stb` are ignored and the shift register holds.
- R7: A low `clr_n` zeroes every shift-register stage in the next cycle. No strobe is needed, and the clear takes priority over load and shift.
- R8: `pin_oe` equals the inverse of `oe_n`. `pin_o` always carries the shift-register stages, and `oe_n` has no effect on capture, load, shift or clear.
- R9: `ser_out` always equals the top stage (bit W-1 of `pin_o`).
- R10: When a `cap_stb` rising edge arrives while a load is active, the newly captured `pin_i` goes into the shift register in that same cycle.
- R11: `conflict` is high exactly while `clr_n` and `ld_n` are both low.
- R12: The synchronous `rst` clears both registers and marks both strobes as previously high, so a strobe that stays high through reset does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | W | Level read from the shared parallel lines |
| ser_a | input | 1 | Serial source 0 |
| ser_b | input | 1 | Serial source 1 |
| ser_sel | input | 1 | Serial source select |
| cap_stb | input | 1 | Holding-register capture strobe |
| sh_stb | input | 1 | Shift strobe |
| sh_en_n | input | 1 | Shift strobe enable, active low |
| ld_n | input | 1 | Parallel load, active low |
| clr_n | input | 1 | Shift-register clear, active low |
| oe_n | input | 1 | Parallel line drive enable, active low |
| pin_o | output | W | Value driven onto the shared lines |
| pin_oe | output | 1 | Drive enable for the shared lines |
| ser_out | output | 1 | Top shift-register stage |
| conflict | output | 1 | Clear and load asserted together |

## Verification
On every cycle, the assertions check how the registers move: capture follows a strobe edge, the holding register stays put when there is none, the clear zeroes the stages, a load follows the forwarded holding value, a load during a high shift strobe changes nothing, an enabled shift moves the stages up by one, and a disabled strobe leaves the stages alone. Only the bench's scenarios can show the end-to-end results. These include the stored word reaching the lines through a load, the serial source choice at stage 0, a long strobe giving a single shift, the same-cycle capture-and-load path, the conflict flag, and the fact that the output enable changes nothing but the drive enable.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int unsigned SSR_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_SHIFT = 2'd3
    } ssr_op_e;

    typedef struct packed {
        logic clr;     // functional clear requested
        logic ld;      // parallel load requested
        logic stb_hi;  // shift strobe currently high
        logic rise;    // shift strobe rising edge this cycle
        logic en;      // shift strobe enabled
    } ssr_ctl_t;

    // Priority: clear, then load (blocked while strobe high), then shift.
    function automatic ssr_op_e ssr_decode(ssr_ctl_t c);
        if (c.clr)            return OP_CLEAR;
        if (c.ld)             return c.stb_hi ? OP_HOLD : OP_LOAD;
        if (c.rise && c.en)   return OP_SHIFT;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/ssr_edge.sv
module ssr_edge (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic rise
);
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b1;
        else     stb_q <= stb;
    end

    assign rise = stb & ~stb_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R4

endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
    parameter int unsigned W = ssr_pkg::SSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] store_q,
    output logic [W-1:0] store_fwd
);
    always_ff @(posedge clk) begin
        if (rst)      store_q <= '0;
        else if (cap) store_q <= din;
    end

    // Value the holding register will have after this edge (same-cycle pass).
    assign store_fwd = cap ? din : store_q;

    AST_CAPTURE_TAKES_PINS: assert property (@(posedge clk) disable iff (rst)
        cap |=> store_q == $past(din)); // R1
    AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(store_q)); // R1

endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
    parameter int unsigned W = ssr_pkg::SSR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ssr_pkg::ssr_ctl_t ctl,
    input  logic              ser_bit,
    input  logic [W-1:0]      load_data,
    output logic [W-1:0]      sh_q
);
    import ssr_pkg::*;

    ssr_op_e      op;
    logic [W-1:0] sh_next;

    assign op = ssr_decode(ctl);

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic from_below;
        if (i == 0) begin : g_first
            assign from_below = ser_bit;
        end else begin : g_rest
            assign from_below = sh_q[i-1];
        end
        assign sh_next[i] = (op == OP_CLEAR) ? 1'b0 :
                            (op == OP_LOAD)  ? load_data[i] :
                            (op == OP_SHIFT) ? from_below : sh_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_next;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> sh_q == '0); // R7
    AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.ld && !ctl.stb_hi) |=> sh_q == $past(load_data)); // R2
    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.ld && ctl.stb_hi) |=> $stable(sh_q)); // R3
    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.ld && ctl.rise && ctl.en)
        |=> (sh_q[W-1:1] == $past(sh_q[W-2:0])) && (sh_q[0] == $past(ser_bit))); // R4
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.ld && !ctl.en) |=> $stable(sh_q)); // R6

endmodule

// File: rtl/ssr_top.sv
module ssr_top #(
    parameter int unsigned W = ssr_pkg::SSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic         ser_a,
    input  logic         ser_b,
    input  logic         ser_sel,
    input  logic         cap_stb,
    input  logic         sh_stb,
    input  logic         sh_en_n,
    input  logic         ld_n,
    input  logic         clr_n,
    input  logic         oe_n,
    output logic [W-1:0] pin_o,
    output logic         pin_oe,
    output logic         ser_out,
    output logic         conflict
);
    import ssr_pkg::*;

    logic         cap_rise;
    logic         sh_rise;
    logic [W-1:0] store_q;
    logic [W-1:0] store_fwd;
    logic [W-1:0] sh_q;
    logic         ser_bit;
    ssr_ctl_t     ctl;

    ssr_edge u_cap_edge (.clk(clk), .rst(rst), .stb(cap_stb), .rise(cap_rise));
    ssr_edge u_sh_edge  (.clk(clk), .rst(rst), .stb(sh_stb),  .rise(sh_rise));

    ssr_store #(.W(W)) u_store (
        .clk(clk), .rst(rst), .cap(cap_rise), .din(pin_i),
        .store_q(store_q), .store_fwd(store_fwd)
    );

    assign ser_bit = ser_sel ? ser_b : ser_a;

    always_comb begin
        ctl        = '0;
        ctl.clr    = ~clr_n;
        ctl.ld     = ~ld_n;
        ctl.stb_hi = sh_stb;
        ctl.rise   = sh_rise;
        ctl.en     = ~sh_en_n;
    end

    ssr_shifter #(.W(W)) u_shift (
        .clk(clk), .rst(rst), .ctl(ctl), .ser_bit(ser_bit),
        .load_data(store_fwd), .sh_q(sh_q)
    );

    assign pin_o    = sh_q;
    assign pin_oe   = ~oe_n;
    assign ser_out  = sh_q[W-1];
    assign conflict = ~clr_n & ~ld_n;

    AST_SEROUT_TOP: assert property (@(posedge clk) disable iff (rst)
        ser_out == pin_o[W-1]); // R9
    AST_CONFLICT_SEEN: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !ld_n) |-> conflict); // R11

endmodule

// File: tb/ssr_top_tb.sv
module ssr_top_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] pin_i;
    logic         ser_a, ser_b, ser_sel, cap_stb, sh_stb, sh_en_n, ld_n, clr_n, oe_n;
    logic [W-1:0] pin_o;
    logic         pin_oe, ser_out, conflict;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ssr_top #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .ser_a(ser_a), .ser_b(ser_b),
        .ser_sel(ser_sel), .cap_stb(cap_stb), .sh_stb(sh_stb), .sh_en_n(sh_en_n),
        .ld_n(ld_n), .clr_n(clr_n), .oe_n(oe_n), .pin_o(pin_o), .pin_oe(pin_oe),
        .ser_out(ser_out), .conflict(conflict)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [W-1:0] v);
        pin_i = v; cap_stb = 1'b1; tick();
        cap_stb = 1'b0; tick();
    endtask

    task automatic load_once();
        ld_n = 1'b0; tick(); ld_n = 1'b1;
    endtask

    task automatic pulse_shift();
        sh_stb = 1'b1; tick(); sh_stb = 1'b0; tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; cap_stb = 1'b1; sh_stb = 1'b1; tick(); tick();
        rst = 1'b0; tick();
        check("R12 stages after reset", pin_o, '0);
        check("R12 no edge from held strobe", pin_o, '0);
        cap_stb = 1'b0; sh_stb = 1'b0; tick();
        ld_n = 1'b0; tick(); ld_n = 1'b1;
        check("R12 holding register after reset", pin_o, '0);
        check("R8 drive enable off", {7'd0, pin_oe}, 8'd0);
        check("R11 no conflict idle", {7'd0, conflict}, 8'd0);
    endtask

    task automatic t_capture_load();
        capture(8'h3C);
        pin_i = 8'hFF; tick();
        check("R1 holding not loaded yet", pin_o, 8'h00);
        load_once();
        check("R1 R2 captured word loaded", pin_o, 8'h3C);
        pin_i = 8'h81; tick(); tick();
        load_once();
        check("R1 holding kept without edge", pin_o, 8'h3C);
    endtask

    task automatic t_load_blocked();
        capture(8'h5A);
        sh_en_n = 1'b1; sh_stb = 1'b1; tick();
        ld_n = 1'b0; tick(); tick();
        check("R3 load blocked while strobe high", pin_o, 8'h3C);
        sh_stb = 1'b0; tick();
        check("R2 level load after strobe falls", pin_o, 8'h5A);
        ld_n = 1'b1; sh_en_n = 1'b0; tick();
    endtask

    task automatic t_shift();
        logic [W-1:0] m;
        capture(8'hA5); load_once(); tick();
        m = 8'hA5;
        ser_a = 1'b1; ser_b = 1'b0; ser_sel = 1'b0;
        pulse_shift(); m = {m[W-2:0], 1'b1};
        check("R4 R5 shift from source 0", pin_o, m);
        check("R9 serial out top stage", {7'd0, ser_out}, {7'd0, m[W-1]});
        ser_sel = 1'b1;
        pulse_shift(); m = {m[W-2:0], 1'b0};
        check("R5 shift from source 1", pin_o, m);
        ser_b = 1'b1; ser_a = 1'b0;
        sh_stb = 1'b1; tick(); tick(); tick(); sh_stb = 1'b0; tick();
        m = {m[W-2:0], 1'b1};
        check("R4 long strobe shifts once", pin_o, m);
        check("R9 serial out after shifts", {7'd0, ser_out}, {7'd0, m[W-1]});
        sh_en_n = 1'b1;
        pulse_shift(); pulse_shift();
        check("R6 disabled strobe ignored", pin_o, m);
        sh_en_n = 1'b0;
    endtask

    task automatic t_clear();
        clr_n = 1'b0; tick();
        check("R7 clear without strobe", pin_o, 8'h00);
        clr_n = 1'b1; capture(8'hC3); load_once();
        check("R7 setup load", pin_o, 8'hC3);
        clr_n = 1'b0; ser_sel = 1'b1; ser_b = 1'b1; sh_stb = 1'b1; tick();
        check("R7 clear beats shift", pin_o, 8'h00);
        check("R9 serial out cleared", {7'd0, ser_out}, 8'd0);
        sh_stb = 1'b0; ld_n = 1'b0; #1;
        check("R11 conflict flagged", {7'd0, conflict}, 8'd1);
        tick();
        check("R7 clear beats load", pin_o, 8'h00);
        clr_n = 1'b1; #1;
        check("R11 conflict drops", {7'd0, conflict}, 8'd0);
        ld_n = 1'b1; tick();
    endtask

    task automatic t_same_cycle();
        ld_n = 1'b0; pin_i = 8'h96; cap_stb = 1'b1; tick();
        check("R10 captured word passes in same cycle", pin_o, 8'h96);
        cap_stb = 1'b0; ld_n = 1'b1; tick();
    endtask

    task automatic t_oe();
        oe_n = 1'b0; #1;
        check("R8 drive enable on", {7'd0, pin_oe}, 8'd1);
        check("R8 lines carry stages", pin_o, 8'h96);
        ser_sel = 1'b0; ser_a = 1'b0;
        pulse_shift();
        check("R8 shift with lines driven", pin_o, 8'h2C);
        oe_n = 1'b1; capture(8'h11); load_once();
        check("R8 capture and load with lines floating", pin_o, 8'h11);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; pin_i = '0; ser_a = 1'b0; ser_b = 1'b0; ser_sel = 1'b0;
        cap_stb = 1'b0; sh_stb = 1'b0; sh_en_n = 1'b0; ld_n = 1'b1;
        clr_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture_load();
        t_load_blocked();
        t_shift();
        t_clear();
        t_same_cycle();
        t_oe();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule